// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block sits between a CPU's register bus and a block-organised flash array. It decides whether program and erase commands may reach each block. Software writes a control register that holds a write-enable bit, a program bit, an erase bit and two verify bits. Two erase-mask registers select which blocks an erase may touch, and a separate register holds a RAM-emulation bit. The block then drives a one-hot program strobe for the addressed block or an erase strobe for every selected block, but only while all protection conditions allow it.

While a program or erase is running, the block watches three CPU event pulses: a flash read (data, vector or instruction fetch), entry to a non-reset exception, and a sleep or software-standby instruction. Any of these aborts the operation at once and sets a sticky error flag. In that error state all configuration registers keep their contents. Program and erase cannot be restarted, but the two verify modes can still be entered. Only reset clears the flag.

The state machine has five states: IDLE (code 0), PROG (1), ERASE (2), PVERIFY (3) and EVERIFY (4).
- An accepted control write chooses the next state in priority order:
  - start-program goes to PROG;
  - start-erase goes to ERASE;
  - enter-pverify goes to PVERIFY;
  - enter-everify goes to EVERIFY;
  - otherwise return-idle goes to IDLE.
- The abort transition takes PROG or ERASE to IDLE and sets the error flag.

Top module: `flash_guard`

## Requirements
- R1: When the write-enable bit (control bit 0) is 0, no program or erase strobe is driven, and a program-bit write does not leave IDLE.
- R2: Block i < MASK_W takes its erase enable from low-mask bit i, and block MASK_W+i from high-mask bit i. In ERASE, erase_stb equals {high mask, low mask}. All-zero masks give no erase strobe.
- R3: While the RAM-emulation bit (register 3 bit 0) is 1, all strobes are 0 and no program or erase can start. The state is kept, and strobes resume when the bit clears.
- R4: A flash read pulse in PROG or ERASE sets the error flag and moves to IDLE one cycle later, and all strobes drop.
- R5: An exception-entry pulse in PROG or ERASE aborts the same way as R4.
- R6: A sleep or standby pulse in PROG or ERASE aborts the same way as R4.
- R7: After an abort, the control register and both mask registers read back unchanged.
- R8: With the error flag set, writing the program bit (1) or the erase bit (2) keeps the state IDLE, while the program-verify bit (3) or the erase-verify bit (4) still enters PVERIFY or EVERIFY.
- R9: The error flag stays set until reset. Reset clears the flag, the state and every register.
- R10: A control write with both the program and erase bits set is ignored entirely.
- R11: In PROG, prog_stb is one-hot at the block index on prog_blk. Writes to the mask registers do not disturb it.
- R12: Event pulses outside PROG and ERASE have no effect.
- R13: status is {error, state code[2:0]}, using the codes listed above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 low mask, 2 high mask, 3 RAM emulation |
| cfg_wdata | input | BUS_W | Write data |
| cfg_rdata | output | BUS_W | Read-back of the register chosen by cfg_sel |
| prog_blk | input | IDX_W | Block index for programming |
| flash_rd_evt | input | 1 | Flash read or fetch pulse |
| exc_evt | input | 1 | Non-reset exception entry pulse |
| sleep_evt | input | 1 | Sleep or standby pulse |
| prog_stb | output | 2*MASK_W | Per-block program strobe |
| erase_stb | output | 2*MASK_W | Per-block erase strobe |
| status | output | 4 | {error, state code} |

## Verification
The bench builds the block with MASK_W=4 and BUS_W=8, which gives eight blocks. Every block index and every mask bit therefore fits in one byte-wide expected value, and each vector checks the whole strobe bus at once. The narrow masks also leave upper write-data bits unused by the masks, so a test can set both the program and erase bits without touching any mask.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_PROG  = 3'd1,
        OP_ERASE = 3'd2,
        OP_PVER  = 3'd3,
        OP_EVER  = 3'd4
    } op_state_e;

    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_MASK_LO = 2'd1,
        SEL_MASK_HI = 2'd2,
        SEL_EMU     = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic ever;
        logic pver;
        logic erase;
        logic prog;
        logic wen;
    } ctrl_t;

    localparam int CTRL_W = 5;

endpackage

// File: rtl/fg_regs.sv
module fg_regs
    import flash_guard_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int MASK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [BUS_W-1:0]  cfg_wdata,
    output logic [BUS_W-1:0]  cfg_rdata,
    output ctrl_t             ctrl,
    output ctrl_t             ctrl_new,
    output logic              ctrl_acc,
    output logic [MASK_W-1:0] mask_lo,
    output logic [MASK_W-1:0] mask_hi,
    output logic              ramemu
);

    reg_sel_e sel;
    logic     both_set;

    always_comb begin
        sel      = reg_sel_e'(cfg_sel);
        ctrl_new = ctrl_t'(cfg_wdata[CTRL_W-1:0]);
        both_set = ctrl_new.prog & ctrl_new.erase;
        ctrl_acc = cfg_we && (sel == SEL_CTRL) && !both_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl    <= '0;
            mask_lo <= '0;
            mask_hi <= '0;
            ramemu  <= 1'b0;
        end else begin
            if (ctrl_acc) begin
                ctrl <= ctrl_new;
            end
            if (cfg_we && sel == SEL_MASK_LO) begin
                mask_lo <= cfg_wdata[MASK_W-1:0];
            end
            if (cfg_we && sel == SEL_MASK_HI) begin
                mask_hi <= cfg_wdata[MASK_W-1:0];
            end
            if (cfg_we && sel == SEL_EMU) begin
                ramemu <= cfg_wdata[0];
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (sel)
            SEL_CTRL:    cfg_rdata[CTRL_W-1:0] = ctrl;
            SEL_MASK_LO: cfg_rdata[MASK_W-1:0] = mask_lo;
            SEL_MASK_HI: cfg_rdata[MASK_W-1:0] = mask_hi;
            SEL_EMU:     cfg_rdata[0]          = ramemu;
            default:     cfg_rdata             = '0;
        endcase
    end

endmodule

// File: rtl/fg_fsm.sv
module fg_fsm
    import flash_guard_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctrl_acc,
    input  ctrl_t     ctrl_new,
    input  logic      ramemu,
    input  logic      rd_evt,
    input  logic      exc_evt,
    input  logic      slp_evt,
    output op_state_e state,
    output logic      err
);

    op_state_e state_q, state_d;
    logic      err_q, err_d;
    logic      busy, fault, allow;

    function automatic op_state_e pick(input ctrl_t c, input logic ok);
        op_state_e r;
        if (c.prog && ok)       r = OP_PROG;
        else if (c.erase && ok) r = OP_ERASE;
        else if (c.pver)        r = OP_PVER;
        else if (c.ever)        r = OP_EVER;
        else                    r = OP_IDLE;
        return r;
    endfunction

    always_comb begin
        busy  = (state_q == OP_PROG) || (state_q == OP_ERASE);
        fault = busy && (rd_evt || exc_evt || slp_evt);
        allow = ctrl_new.wen && !ramemu && !err_q;
    end

    always_comb begin
        state_d = state_q;
        err_d   = err_q;
        unique case (state_q)
            OP_PROG, OP_ERASE: begin
                if (fault) begin
                    state_d = OP_IDLE;
                    err_d   = 1'b1;
                end else if (ctrl_acc) begin
                    state_d = pick(ctrl_new, allow);
                end
            end
            OP_IDLE, OP_PVER, OP_EVER: begin
                if (ctrl_acc) begin
                    state_d = pick(ctrl_new, allow);
                end
            end
            default: state_d = OP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OP_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
        end
    end

    always_comb begin
        state = state_q;
        err   = err_q;
    end

endmodule

// File: rtl/fg_gate.sv
module fg_gate
    import flash_guard_pkg::*;
#(
    parameter int NBLK  = 16,
    parameter int IDX_W = 4
) (
    input  op_state_e        state,
    input  logic             err,
    input  logic             wen,
    input  logic             ramemu,
    input  logic [NBLK-1:0]  mask_all,
    input  logic [IDX_W-1:0] prog_blk,
    output logic [NBLK-1:0]  prog_stb,
    output logic [NBLK-1:0]  erase_stb
);

    logic permit, do_prog, do_erase;

    always_comb begin
        permit   = wen && !ramemu && !err;
        do_prog  = permit && (state == OP_PROG);
        do_erase = permit && (state == OP_ERASE);
    end

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        localparam logic [IDX_W-1:0] BIDX = IDX_W'(b);
        assign prog_stb[b]  = do_prog && (prog_blk == BIDX);
        assign erase_stb[b] = do_erase && mask_all[b];
    end

endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int MASK_W = 8,
    localparam int NBLK  = 2 * MASK_W,
    localparam int IDX_W = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [BUS_W-1:0] cfg_wdata,
    output logic [BUS_W-1:0] cfg_rdata,
    input  logic [IDX_W-1:0] prog_blk,
    input  logic             flash_rd_evt,
    input  logic             exc_evt,
    input  logic             sleep_evt,
    output logic [NBLK-1:0]  prog_stb,
    output logic [NBLK-1:0]  erase_stb,
    output logic [3:0]       status
);

    ctrl_t             ctrl, ctrl_new;
    logic              ctrl_acc;
    logic [MASK_W-1:0] mask_lo, mask_hi;
    logic [NBLK-1:0]   mask_all;
    logic              ramemu;
    op_state_e         state;
    logic              err;

    fg_regs #(.BUS_W(BUS_W), .MASK_W(MASK_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .ctrl     (ctrl),
        .ctrl_new (ctrl_new),
        .ctrl_acc (ctrl_acc),
        .mask_lo  (mask_lo),
        .mask_hi  (mask_hi),
        .ramemu   (ramemu)
    );

    fg_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_acc(ctrl_acc),
        .ctrl_new(ctrl_new),
        .ramemu  (ramemu),
        .rd_evt  (flash_rd_evt),
        .exc_evt (exc_evt),
        .slp_evt (sleep_evt),
        .state   (state),
        .err     (err)
    );

    assign mask_all = {mask_hi, mask_lo};

    fg_gate #(.NBLK(NBLK), .IDX_W(IDX_W)) u_gate (
        .state    (state),
        .err      (err),
        .wen      (ctrl.wen),
        .ramemu   (ramemu),
        .mask_all (mask_all),
        .prog_blk (prog_blk),
        .prog_stb (prog_stb),
        .erase_stb(erase_stb)
    );

    assign status = {err, state};

endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
    parameter int NBLK = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            swe,
    input logic            rams,
    input logic            err,
    input logic [2:0]      state,
    input logic [NBLK-1:0] mask_all,
    input logic            rd_evt,
    input logic            exc_evt,
    input logic            slp_evt,
    input logic            cfg_we,
    input logic [NBLK-1:0] prog_stb,
    input logic [NBLK-1:0] erase_stb
);

    logic busy;
    assign busy = (state == 3'd1) || (state == 3'd2);

    assert_swe_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !swe |-> (prog_stb == '0 && erase_stb == '0));

    assert_mask_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_stb & ~mask_all) == '0);

    assert_emu_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rams |-> (prog_stb == '0 && erase_stb == '0));

    assert_rd_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_evt) |=> (err && state == 3'd0));

    assert_exc_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && exc_evt) |=> (err && state == 3'd0));

    assert_slp_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && slp_evt) |=> (err && state == 3'd0));

    assert_err_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (prog_stb == '0 && erase_stb == '0));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    assert_prog_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(prog_stb));

    assert_idle_event_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !err) |=> !err);

endmodule

bind flash_guard flash_guard_chk #(.NBLK(NBLK)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .swe      (ctrl.wen),
    .rams     (ramemu),
    .err      (err),
    .state    (state),
    .mask_all (mask_all),
    .rd_evt   (flash_rd_evt),
    .exc_evt  (exc_evt),
    .slp_evt  (sleep_evt),
    .cfg_we   (cfg_we),
    .prog_stb (prog_stb),
    .erase_stb(erase_stb)
);

// File: tb/tb_flash_guard.sv
`timescale 1ns/1ps
module tb_flash_guard;

    localparam int BUS_W  = 8;
    localparam int MASK_W = 4;
    localparam int NBLK   = 2 * MASK_W;
    localparam int IDX_W  = $clog2(NBLK);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_sel = '0;
    logic [BUS_W-1:0] cfg_wdata = '0;
    logic [BUS_W-1:0] cfg_rdata;
    logic [IDX_W-1:0] prog_blk = '0;
    logic             flash_rd_evt = 1'b0;
    logic             exc_evt = 1'b0;
    logic             sleep_evt = 1'b0;
    logic [NBLK-1:0]  prog_stb, erase_stb;
    logic [3:0]       status;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    flash_guard #(.BUS_W(BUS_W), .MASK_W(MASK_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .prog_blk(prog_blk),
        .flash_rd_evt(flash_rd_evt), .exc_evt(exc_evt), .sleep_evt(sleep_evt),
        .prog_stb(prog_stb), .erase_stb(erase_stb), .status(status)
    );

    typedef struct packed {
        logic [1:0] sel;
        logic [7:0] data;
        logic [2:0] blk;
        logic [7:0] ep;
        logic [7:0] ee;
        logic [3:0] es;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{2'd3, 8'h00, 3'd0, 8'h00, 8'h00, 4'h0, 4'd3 },  // R3 emu off
        '{2'd1, 8'h05, 3'd0, 8'h00, 8'h00, 4'h0, 4'd2 },  // R2 low mask
        '{2'd2, 8'h08, 3'd0, 8'h00, 8'h00, 4'h0, 4'd2 },  // R2 high mask
        '{2'd0, 8'h05, 3'd0, 8'h00, 8'h85, 4'h2, 4'd2 },  // R2 erase follows masks
        '{2'd0, 8'h01, 3'd0, 8'h00, 8'h00, 4'h0, 4'd13},  // R13 idle
        '{2'd0, 8'h02, 3'd0, 8'h00, 8'h00, 4'h0, 4'd1 },  // R1 no wen
        '{2'd0, 8'h03, 3'd5, 8'h20, 8'h00, 4'h1, 4'd11},  // R11 block 5
        '{2'd0, 8'h03, 3'd2, 8'h04, 8'h00, 4'h1, 4'd11},  // R11 block 2
        '{2'd3, 8'h01, 3'd5, 8'h00, 8'h00, 4'h1, 4'd3 },  // R3 emu gates
        '{2'd3, 8'h00, 3'd5, 8'h20, 8'h00, 4'h1, 4'd3 },  // R3 resume
        '{2'd0, 8'h07, 3'd5, 8'h20, 8'h00, 4'h1, 4'd10},  // R10 both ignored
        '{2'd1, 8'h00, 3'd5, 8'h20, 8'h00, 4'h1, 4'd11},  // R11 mask write
        '{2'd2, 8'h00, 3'd5, 8'h20, 8'h00, 4'h1, 4'd11},  // R11 mask write
        '{2'd0, 8'h05, 3'd0, 8'h00, 8'h00, 4'h2, 4'd2 },  // R2 zero masks
        '{2'd0, 8'h09, 3'd0, 8'h00, 8'h00, 4'h3, 4'd13},  // R13 pverify
        '{2'd0, 8'h11, 3'd0, 8'h00, 8'h00, 4'h4, 4'd13},  // R13 everify
        '{2'd0, 8'h00, 3'd0, 8'h00, 8'h00, 4'h0, 4'd13}   // R13 idle
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        cfg_sel = s; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] d);
        @(negedge clk);
        cfg_sel = s;
        #1;
        d = cfg_rdata;
    endtask

    task automatic pulse(input int k);
        @(negedge clk);
        case (k)
            0: flash_rd_evt = 1'b1;
            1: exc_evt = 1'b1;
            default: sleep_evt = 1'b1;
        endcase
        @(negedge clk);
        flash_rd_evt = 1'b0; exc_evt = 1'b0; sleep_evt = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [7:0] rb;
        do_reset();
        // R9: reset state
        chk("R9 reset status", 32'(status), 32'h0);
        chk("R9 reset prog", 32'(prog_stb), 32'h0);
        chk("R9 reset erase", 32'(erase_stb), 32'h0);
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), rb);
            chk("R9 reset readback", 32'(rb), 32'h0);
        end

        for (int i = 0; i < NV; i++) begin
            prog_blk = VECS[i].blk;
            wr(VECS[i].sel, VECS[i].data);
            checks++;
            if (prog_stb !== VECS[i].ep || erase_stb !== VECS[i].ee || status !== VECS[i].es) begin
                errors++;
                $display("FAIL R%0d vec %0d actual p=%h e=%h s=%h expected p=%h e=%h s=%h",
                         VECS[i].rq, i, prog_stb, erase_stb, status,
                         VECS[i].ep, VECS[i].ee, VECS[i].es);
            end
        end

        // R12: events outside program/erase
        do_reset();
        for (int k = 0; k < 3; k++) begin
            pulse(k);
            chk("R12 idle event", 32'(status), 32'h0);
        end
        wr(2'd0, 8'h09);
        pulse(2);
        chk("R12 verify event", 32'(status), 32'h3);

        // R4 R5 R6 aborts, with R7 R8 R9 in the error state
        for (int k = 0; k < 3; k++) begin
            do_reset();
            prog_blk = 3'd6;
            wr(2'd1, 8'h03);
            wr(2'd0, (k == 1) ? 8'h03 : 8'h05);
            chk("R4 R5 R6 active", 32'(status), (k == 1) ? 32'h1 : 32'h2);
            pulse(k);
            if (k == 0) chk("R4 read abort status", 32'(status), 32'h8);
            if (k == 1) chk("R5 exception abort status", 32'(status), 32'h8);
            if (k == 2) chk("R6 sleep abort status", 32'(status), 32'h8);
            chk("R4 R5 R6 strobes off", 32'({prog_stb, erase_stb}), 32'h0);
            rd(2'd0, rb);
            chk("R7 ctrl kept", 32'(rb), (k == 1) ? 32'h03 : 32'h05);
            rd(2'd1, rb);
            chk("R7 mask kept", 32'(rb), 32'h03);
            wr(2'd0, 8'h03);
            chk("R8 program refused", 32'(status), 32'h8);
            wr(2'd0, 8'h05);
            chk("R8 erase refused", 32'(status), 32'h8);
            chk("R8 no strobe", 32'({prog_stb, erase_stb}), 32'h0);
            wr(2'd0, 8'h09);
            chk("R8 pverify allowed", 32'(status), 32'hB);
            wr(2'd0, 8'h11);
            chk("R8 everify allowed", 32'(status), 32'hC);
            wr(2'd0, 8'h00);
            repeat (3) @(negedge clk);
            chk("R9 error sticky", 32'(status), 32'h8);
        end
        do_reset();
        chk("R9 reset clears error", 32'(status), 32'h0);
        rd(2'd0, rb);
        chk("R9 reset clears ctrl", 32'(rb), 32'h0);
        rd(2'd1, rb);
        chk("R9 reset clears mask", 32'(rb), 32'h0);

        // R1: clearing write-enable mid-program stops it
        wr(2'd0, 8'h03);
        wr(2'd0, 8'h02);
        chk("R1 wen cleared", 32'({status, prog_stb}), 32'h0);

        done = 1;
        summary();
    end

endmodule